// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a processor with fixed 32-bit, word-aligned instructions. On every clock edge it picks the next fetch address and loads it into the counter. There are four candidates:

- the sequential fall-through address;
- a conditional PC-relative branch target;
- a jump target built by splicing an instruction field into the upper page bits of the current PC;
- a full 32-bit target taken from a register operand.

The decode stage supplies the instruction word, four one-hot-style control strobes and the two register operand values. The unit does the target arithmetic and the equality compare for branches itself. All candidate addresses are available as outputs, together with the chosen next address, so that neighbouring logic can observe them. A stall input freezes the counter.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous active-low reset loads the PC with the parameter START_ADDR (default 0x00400000).
- R2: With no control strobe asserted and no stall, the PC advances by 4 each cycle, wrapping modulo 2^32.
- R3: `branch_addr` always equals `seq_addr` plus the sign-extended `instr[15:0]` multiplied by 4, where `seq_addr` = PC + 4. The reach therefore spans -32768 to +32767 words from the following instruction.
- R4: `br_taken` is 1 when `ctl_beq` is set and the operands are equal, or when `ctl_bne` is set and they differ. A taken branch loads `branch_addr`. An untaken branch loads `seq_addr`.
- R5: `jump_addr` is {PC[31:28], instr[25:0], 2'b00}, and `ctl_jmp` loads it. The opcode in instr[31:26] has no effect on the target.
- R6: `ctl_jreg` loads `opnd_a` with bits 1:0 cleared. `jr_misalign` is 1 exactly when `ctl_jreg` is set and `opnd_a[1:0]` is nonzero.
- R7: Priority order is `ctl_jreg` first, then `ctl_jmp`, then a taken branch, then sequential.
- R8: While `stall` is 1 the PC holds its value.
- R9: PC bits 1:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Hold PC |
| instr | input | 32 | Current instruction word |
| ctl_beq | input | 1 | Branch if operands equal |
| ctl_bne | input | 1 | Branch if operands differ |
| ctl_jmp | input | 1 | Pseudodirect jump |
| ctl_jreg | input | 1 | Register-indirect jump |
| opnd_a | input | 32 | First register operand / jump register |
| opnd_b | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| seq_addr | output | 32 | PC + 4 |
| branch_addr | output | 32 | Branch target |
| jump_addr | output | 32 | Pseudodirect jump target |
| next_pc | output | 32 | Selected next address |
| br_taken | output | 1 | Branch condition met |
| jr_misalign | output | 1 | Register target low bits nonzero |

## Verification
The pseudodirect jump keeps the upper four PC bits. Its behaviour across a page boundary only shows when the PC already sits near the top of a 256 MB page or of the address space. Random operands almost never reach that state through sequential steps.

The stimulus therefore uses register jumps to place the PC at chosen addresses, such as 0xFFFFFFFC and 0x7FFFFFF8. From there it exercises jumps, extreme branch offsets and the wrap of PC + 4. Random vectors then mix all strobes, including several at once, with operand equality forced half the time.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic        ctl_beq,
  input  logic        ctl_bne,
  input  logic        ctl_jmp,
  input  logic        ctl_jreg,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  output logic [31:0] pc,
  output logic [31:0] seq_addr,
  output logic [31:0] branch_addr,
  output logic [31:0] jump_addr,
  output logic [31:0] next_pc,
  output logic        br_taken,
  output logic        jr_misalign
);

  logic [31:0] pc_q;
  logic [31:0] jreg_addr;
  logic        ops_eq;

  assign pc          = pc_q;
  assign seq_addr    = pc_q + 32'd4;
  assign branch_addr = seq_addr + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jump_addr   = {pc_q[31:28], instr[25:0], 2'b00};
  assign jreg_addr   = {opnd_a[31:2], 2'b00};
  assign ops_eq      = (opnd_a == opnd_b);
  assign br_taken    = (ctl_beq & ops_eq) | (ctl_bne & ~ops_eq);
  assign jr_misalign = ctl_jreg & (opnd_a[1:0] != 2'b00);

  always_comb begin
    if (ctl_jreg)      next_pc = jreg_addr;
    else if (ctl_jmp)  next_pc = jump_addr;
    else if (br_taken) next_pc = branch_addr;
    else               next_pc = seq_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= {START_ADDR[31:2], 2'b00};
    else if (!stall) pc_q <= next_pc;
  end

endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        ctl_beq,
  input logic        ctl_bne,
  input logic        ctl_jmp,
  input logic        ctl_jreg,
  input logic [31:0] opnd_a,
  input logic [31:0] pc,
  input logic        jr_misalign
);

  AST_RESET_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> pc == {START_ADDR[31:2], 2'b00}); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!stall && !ctl_jreg && !ctl_jmp && !ctl_beq && !ctl_bne) |=> pc == $past(pc) + 32'd4); // R2
  AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n) (!stall && ctl_jmp && !ctl_jreg) |=> pc[31:28] == $past(pc[31:28])); // R5
  AST_MISALIGN_ONLY_JREG: assert property (@(posedge clk) disable iff (!rst_n) jr_misalign |-> ctl_jreg); // R6
  AST_JREG_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (!stall && ctl_jreg) |=> pc == {$past(opnd_a[31:2]), 2'b00}); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(pc)); // R8
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) pc[1:0] == 2'b00); // R9

endmodule

bind pc_next_unit pc_next_unit_chk #(.START_ADDR(START_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .ctl_beq(ctl_beq), .ctl_bne(ctl_bne),
  .ctl_jmp(ctl_jmp), .ctl_jreg(ctl_jreg), .opnd_a(opnd_a), .pc(pc),
  .jr_misalign(jr_misalign)
);

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
  localparam logic [31:0] START = 32'h0040_0000;

  logic clk = 0, rst_n = 0, stall = 0;
  logic [31:0] instr = 0, opnd_a = 0, opnd_b = 0;
  logic ctl_beq = 0, ctl_bne = 0, ctl_jmp = 0, ctl_jreg = 0;
  logic [31:0] pc, seq_addr, branch_addr, jump_addr, next_pc;
  logic br_taken, jr_misalign;

  int checks = 0, fails = 0;
  logic [31:0] model_pc;
  bit done = 0;

  always #2 clk = ~clk;

  pc_next_unit #(.START_ADDR(START)) i_pc_next_unit (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .ctl_beq(ctl_beq), .ctl_bne(ctl_bne), .ctl_jmp(ctl_jmp), .ctl_jreg(ctl_jreg),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pc(pc), .seq_addr(seq_addr),
    .branch_addr(branch_addr), .jump_addr(jump_addr), .next_pc(next_pc),
    .br_taken(br_taken), .jr_misalign(jr_misalign)
  );

  function automatic logic [31:0] f_branch(logic [31:0] p, logic [31:0] ins);
    int off;
    off = int'($signed(ins[15:0])) * 4;
    return p + 32'd4 + 32'(off);
  endfunction

  function automatic logic f_taken(logic beq, logic bne, logic [31:0] a, logic [31:0] b);
    return (beq && a == b) || (bne && a != b);
  endfunction

  function automatic logic [31:0] f_next(logic [31:0] p, logic [31:0] ins, logic beq, logic bne,
                                         logic jmp, logic jr, logic [31:0] a, logic [31:0] b);
    if (jr) return a & 32'hFFFF_FFFC;
    if (jmp) return {p[31:28], ins[25:0], 2'b00};
    if (f_taken(beq, bne, a, b)) return f_branch(p, ins);
    return p + 32'd4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [31:0] ins, logic beq, logic bne, logic jmp, logic jr,
                      logic [31:0] a, logic [31:0] b, logic stl);
    logic [31:0] exp_n;
    instr = ins; ctl_beq = beq; ctl_bne = bne; ctl_jmp = jmp; ctl_jreg = jr;
    opnd_a = a; opnd_b = b; stall = stl;
    #1;
    exp_n = f_next(model_pc, ins, beq, bne, jmp, jr, a, b);
    chk({tag, " R2 seq_addr"}, seq_addr, model_pc + 32'd4);
    chk({tag, " R3 branch_addr"}, branch_addr, f_branch(model_pc, ins));
    chk({tag, " R4 br_taken"}, {31'd0, br_taken}, {31'd0, f_taken(beq, bne, a, b)});
    chk({tag, " R5 jump_addr"}, jump_addr, {model_pc[31:28], ins[25:0], 2'b00});
    chk({tag, " R6 jr_misalign"}, {31'd0, jr_misalign}, {31'd0, jr && (a[1:0] != 2'b00)});
    chk({tag, " R7 next_pc"}, next_pc, exp_n);
    @(posedge clk);
    @(negedge clk);
    if (!stl) model_pc = exp_n;
    chk({tag, stl ? " R8 pc held" : " R4 pc"}, pc, model_pc);
    chk({tag, " R9 pc aligned"}, {30'd0, pc[1:0]}, 32'd0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_pc = START + 32'd4;
    // R1: one edge after release the PC has advanced once from START
    chk("R1 reset start", pc, model_pc);
    rst_n = 0; @(negedge clk); rst_n = 1;
    model_pc = START;
    chk("R1 reset value", pc, START);
    #1 model_pc = pc;
    @(negedge clk); model_pc = model_pc + 4; // free step

    step("R2 seq", 32'h0, 0, 0, 0, 0, 1, 2, 0);
    step("R4 beq taken", 32'h1000_0003, 1, 0, 0, 0, 7, 7, 0);
    step("R4 beq not", 32'h1000_0003, 1, 0, 0, 0, 7, 8, 0);
    step("R4 bne taken", 32'h1400_FFFE, 0, 1, 0, 0, 7, 8, 0);
    step("R4 bne not", 32'h1400_FFFE, 0, 1, 0, 0, 9, 9, 0);
    step("R6 jreg misaligned", 32'h0, 0, 0, 0, 1, 32'h7FFF_FFFB, 0, 0);
    step("R3 max neg offset", 32'h1000_8000, 1, 0, 0, 0, 3, 3, 0);
    step("R6 jreg aligned", 32'h0, 0, 0, 0, 1, 32'h0FFF_FFF0, 0, 0);
    step("R3 max pos offset", 32'h1000_7FFF, 1, 0, 0, 0, 3, 3, 0);
    step("R5 jump", 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 0);
    step("R7 all set", 32'h0800_0010, 1, 1, 1, 1, 32'h0000_0100, 5, 0);
    step("R7 jmp over branch", 32'h0BAD_0001, 1, 0, 1, 0, 4, 4, 0);
    step("R8 stall", 32'h0, 0, 0, 1, 1, 32'h1234_5678, 0, 1);
    step("R8 stall seq", 32'h0, 0, 0, 0, 0, 0, 1, 1);
    step("R2 wrap setup", 32'h0, 0, 0, 0, 1, 32'hFFFF_FFFC, 0, 0);
    step("R2 wrap", 32'h0, 0, 0, 0, 0, 0, 1, 0);
    step("R5 page top setup", 32'h0, 0, 0, 0, 1, 32'hEFFF_FFFC, 0, 0);
    step("R5 page top jump", 32'h03FF_FFFF, 0, 0, 1, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [3:0] c;
      a = $urandom;
      b = ($urandom % 2) ? a : $urandom;
      c = 4'($urandom);
      if (($urandom % 4) != 0) c[3] = 1'b0;
      step("R7 random", $urandom, c[0], c[1], c[2], c[3], a, b, ($urandom % 8) == 0);
    end

    rst_n = 0; @(negedge clk); rst_n = 1;
    chk("R1 reset again", pc, START);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule